// File: doc/BRIEF.md
# Dual-Order Burst Address Counter

This block produces the two low address bits of a four-beat memory burst. When an access starts, it captures the two least-significant bits of the incoming address. On each later cycle in which the burst advances, it moves to the next beat. The upper address bits do not pass through this block, and chip-enable decoding is done elsewhere.

Two beat orders are available, and a static mode input selects between them. Linear order counts up modulo four from the start value. Interleaved order toggles bits of the start value in a fixed pattern. In both orders the burst can pause for any number of cycles and then resume from the beat it had reached. After the fourth beat it wraps back to the start value.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next value of `burst_lo` is 2'b00.
- R2: After a rising edge with `ld` high, `burst_lo` equals the `seed` value sampled at that edge, in either order.
- R3: With `order_ilv` low, beat k of a burst (k = 0..3, beat 0 being the loaded value) is (seed + k) modulo 4. For example, seed 2'b01 gives 01, 10, 11, 00.
- R4: With `order_ilv` high, beat k is seed XOR k. The start values give these sequences: 00 gives 00,01,10,11; 01 gives 01,00,11,10; 10 gives 10,11,00,01; 11 gives 11,10,01,00.
- R5: The burst moves one beat at a rising edge only when `adv_n` is low and `ld` is low. When `adv_n` is high and `ld` is low, `burst_lo` holds its value. Any number of such pause cycles keeps the burst position.
- R6: After four advances the sequence returns to the start value and repeats the same pattern.
- R7: When `ld` and `adv_n` are both asserted at the same edge, the load wins. The output becomes `seed` (beat 0) and does not move to beat 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld | input | 1 | Start a new burst from `seed` |
| seed | input | 2 | Low address bits of the starting address |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_lo | output | 2 | Current low address bits of the burst |

## Verification
The assertions assume that `order_ilv` is a static strap: it stays constant for the whole of a burst. The order assertions also let off any cycle in which the mode has just changed. The stimulus changes the mode only on a load cycle, and it keeps reset asserted for two edges before any burst starts. Loads, pauses, advances and a load that coincides with an advance are applied in both modes for all four start values. Each run passes the wrap point at least once.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [1:0] seed,
  input  logic       adv_n,
  input  logic       order_ilv,
  output logic [1:0] burst_lo
);

  localparam int W = 2;

  logic [W-1:0] base_q;
  logic [W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (ld) begin
      base_q <= seed;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign burst_lo = order_ilv ? (base_q ^ beat_q) : (base_q + beat_q);

  // load captures seed, and wins over a simultaneous advance
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (burst_lo == $past(seed)));

  assert_load_beats_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !adv_n) |=> (burst_lo == $past(seed)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> ($stable(burst_lo) || !$stable(order_ilv)));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && !order_ilv) |=>
      (order_ilv || burst_lo == W'($past(burst_lo) + 2'd1)));

  assert_ilv_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && order_ilv) |=>
      (!order_ilv || burst_lo[0] != $past(burst_lo[0])));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld = 1'b0;
  logic [1:0] seed = 2'b00;
  logic       adv_n = 1'b1;
  logic       order_ilv = 1'b1;
  logic [1:0] burst_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  logic [1:0] m_start;
  int         m_k;

  always #2 clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .seed(seed),
    .adv_n(adv_n), .order_ilv(order_ilv), .burst_lo(burst_lo)
  );

  function automatic logic [1:0] beat_of(input logic [1:0] s, input int k, input logic ilv);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return ilv ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic cyc(input logic r, input logic l, input logic [1:0] sd,
                     input logic a_n, input logic ilv, input string tag);
    @(negedge clk);
    rst_n = r; ld = l; seed = sd; adv_n = a_n; order_ilv = ilv;
    @(posedge clk);
    if (!r) begin
      m_start = 2'b00; m_k = 0;
      exp_q.push_back(2'b00);
    end else begin
      if (l) begin m_start = sd; m_k = 0; end
      else if (!a_n) m_k = m_k + 1;
      exp_q.push_back(beat_of(m_start, m_k, ilv));
    end
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (burst_lo !== e) begin
          n_bad++;
          $display("FAIL %s: burst_lo=%b expected=%b", t, burst_lo, e);
        end
      end
    end
  end

  initial begin
    cyc(1'b0, 1'b0, 2'b11, 1'b0, 1'b1, "R1");
    cyc(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, "R1");
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int s = 0; s < 4; s++) begin
        string oT;
        oT = (ilv != 0) ? "R4" : "R3";
        cyc(1'b1, 1'b1, 2'(s), 1'b1, 1'(ilv), "R2");
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), oT);
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), oT);
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'(ilv), "R5");
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'(ilv), "R5");
        cyc(1'b1, 1'b1 & 1'b0, 2'b11, 1'b1, 1'(ilv), "R5");
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), oT);
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), "R6");
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), "R6");
        cyc(1'b1, 1'b1, 2'(3 - s), 1'b0, 1'(ilv), "R7");
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), oT);
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'(ilv), "R5");
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'(ilv), oT);
      end
    end
    @(negedge clk);
    adv_n = 1'b1;
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule